// File: doc/BRIEF.md
# Serial Audio Transmitter with Slot-Aware Underrun Muting

This block is the transmit half of a serial audio port running as clock master. Samples are written into an eight-word FIFO. The block produces the bit clock and the frame sync itself and shifts each sample out on a single data line. The sample width, the frame length, stereo or mono packing and the bit order are all configuration inputs. A level-based request line asks a DMA engine, or software, to refill the FIFO before it drains.

If the FIFO is empty when a slot needs a sample, the block sends silence and remembers which slot went without data. It keeps sending silence until a slot with that same index comes round while the FIFO holds a word. Only then does it take the next word. Because of this, the samples in memory stay locked to their left/right positions even after a starvation event.

Clearing the enable input does not cut a frame short. The running frame finishes, and the activity output stays high until the block has stopped on the frame boundary. When the block starts, it checks the programmed frame length and sets a sticky flag if that length does not suit a master clock.

Top module: `aud_tx`

## Requirements
- R1: `cfg_size` selects the sample width: 3'b010 gives 8 bits, 3'b011 gives 10, 3'b100 gives 16, 3'b101 gives 20, 3'b110 gives 24 and 3'b111 gives 32. Codes 000 and 001 act as 8 bits. The sample is taken from the low bits of the FIFO word and placed at the start of its slot. Slot bits after the sample are 0, and sample bits that do not fit in the slot are not sent.
- R2: One frame lasts `cfg_frl`+1 bit periods, and one bit period is two `clk` cycles. Slot 0 covers the first floor((`cfg_frl`+1)/2) bits and slot 1 covers the rest. `fsync` is high during slot 0 and low during slot 1.
- R3: In stereo (`cfg_mono`=0), each frame takes one FIFO word for slot 0 and then one for slot 1. In mono, the frame takes one word and sends it in both slots.
- R4: `cfg_lsb_first`=0 sends the sample MSB first, and `cfg_lsb_first`=1 sends it LSB first.
- R5: The FIFO holds 8 words. `fifo_level` reports how many words it holds. A write while the FIFO is full is dropped, and the stored words are then sent in write order.
- R6: `dreq` is high while `fifo_level` is at or below a limit set by `cfg_thresh`: 0 gives a limit of 0, 1 gives 2, 2 gives 4, 3 gives 6, and 4 to 7 give 7.
- R7: If a slot finds the FIFO empty, that slot sends zeros and its index is recorded. Later slots send zeros, and take no word, until a slot with the recorded index finds a word. That word is sent, and normal output resumes from there.
- R8: An underrun sets `urun_flag`, which stays set until `flag_clr` is pulsed. `urun_irq` is high only while both `urun_flag` and `urun_ie` are high.
- R9: After `enable` falls, the block finishes the current frame and then stops. `active` stays high until that frame boundary, and no partial frame is sent.
- R10: When the block starts with `cfg_mclk_on`=1, `wck_err` is set if `cfg_frl`+1 is not a power of two or is below 8. It stays set until `flag_clr` is pulsed.
- R11: After reset, `active`, `sclk`, `fsync`, `sdata`, `urun_flag`, `wck_err` and `fifo_level` are 0, and `dreq` is 1.
- R12: While the block is idle, `sclk`, `fsync` and `sdata` are low. While it runs, `sclk` toggles on every `clk` cycle, and `sdata` changes only when `sclk` falls (the first bit is driven at start).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Run request; when cleared, the block stops at the end of the current frame |
| cfg_size | input | 3 | Sample width code |
| cfg_frl | input | 8 | Frame length minus one, in bit periods |
| cfg_mono | input | 1 | 1: one word per frame, repeated in both slots |
| cfg_lsb_first | input | 1 | 1: sample sent LSB first |
| cfg_mclk_on | input | 1 | Master clock in use; enables the frame-length check |
| cfg_thresh | input | 3 | Refill request level code |
| urun_ie | input | 1 | Underrun interrupt enable |
| flag_clr | input | 1 | Clears both sticky flags |
| wr_en | input | 1 | FIFO write strobe |
| wr_data | input | 32 | FIFO write word |
| fifo_level | output | 4 | Number of words in the FIFO |
| dreq | output | 1 | Refill request |
| active | output | 1 | High while the block is running |
| sclk | output | 1 | Bit clock |
| fsync | output | 1 | Frame sync |
| sdata | output | 1 | Serial data |
| urun_flag | output | 1 | Sticky underrun flag |
| urun_irq | output | 1 | Gated underrun interrupt |
| wck_err | output | 1 | Sticky frame-length configuration error |

## Verification
A wrong bit position or slot boundary shows up on `sdata` or `fsync` in the frame where it occurs, so every sent frame is rebuilt bit by bit from the pins and compared. A wrong recorded slot, or a mute that clears at the wrong slot, moves every later sample by one slot. The underrun case therefore checks the two frames that follow the miss, since the slot-0 word of the first of them would expose an early recovery. A FIFO pointer or level fault shows up as a missing or extra word in the next frame, and through `dreq` and `fifo_level` as soon as the next write is made. An early stop shows as a short capture, and a late stop shows as `active` staying high beyond one frame.

// File: rtl/aud_tx_pkg.sv
package aud_tx_pkg;

    // Sample width in bits for a width code; reserved codes fall back to 8.
    function automatic logic [5:0] size_bits(input logic [2:0] code);
        case (code)
            3'b011:  return 6'd10;
            3'b100:  return 6'd16;
            3'b101:  return 6'd20;
            3'b110:  return 6'd24;
            3'b111:  return 6'd32;
            default: return 6'd8;
        endcase
    endfunction

endpackage

// File: rtl/aud_tx_fifo.sv
module aud_tx_fifo #(
    parameter int DEPTH = 8,
    parameter int DW    = 32,
    localparam int AW   = $clog2(DEPTH),
    localparam int LVW  = AW + 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           push,
    input  logic [DW-1:0]  push_data,
    input  logic           pop,
    output logic [DW-1:0]  head,
    output logic [LVW-1:0] level
);
    logic [DW-1:0]  mem [DEPTH];
    logic [AW-1:0]  wp_q, wp_d, rp_q, rp_d;
    logic [LVW-1:0] cnt_q, cnt_d;
    logic           do_push, do_pop;

    always_comb begin
        do_push = push && (cnt_q < LVW'(DEPTH));
        do_pop  = pop && (cnt_q != '0);
        wp_d    = do_push ? ((wp_q == AW'(DEPTH - 1)) ? '0 : wp_q + 1'b1) : wp_q;
        rp_d    = do_pop  ? ((rp_q == AW'(DEPTH - 1)) ? '0 : rp_q + 1'b1) : rp_q;
        cnt_d   = cnt_q + LVW'(do_push) - LVW'(do_pop);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp_q  <= '0;
            rp_q  <= '0;
            cnt_q <= '0;
        end else begin
            wp_q  <= wp_d;
            rp_q  <= rp_d;
            cnt_q <= cnt_d;
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[wp_q] <= push_data;
    end

    assign head  = mem[rp_q];
    assign level = cnt_q;
endmodule

// File: rtl/aud_tx_thresh.sv
module aud_tx_thresh #(
    parameter int DEPTH = 8,
    localparam int LVW  = $clog2(DEPTH) + 1
) (
    input  logic [2:0]     thresh,
    input  logic [LVW-1:0] level,
    output logic           req
);
    logic [LVW-1:0] lim;

    always_comb begin
        case (thresh)
            3'd0:    lim = '0;
            3'd1:    lim = LVW'(DEPTH / 4);
            3'd2:    lim = LVW'(DEPTH / 2);
            3'd3:    lim = LVW'((3 * DEPTH) / 4);
            default: lim = LVW'(DEPTH - 1);
        endcase
        req = (level <= lim);
    end
endmodule

// File: rtl/aud_tx_bitsel.sv
module aud_tx_bitsel #(
    parameter int DW = 32
) (
    input  logic          run,
    input  logic [DW-1:0] word,
    input  logic [7:0]    pos,
    input  logic [8:0]    half,
    input  logic [2:0]    size_code,
    input  logic          lsb_first,
    output logic          bit_out
);
    import aud_tx_pkg::*;

    logic [8:0] k;
    logic [5:0] width;
    int         idx;

    always_comb begin
        width = size_bits(size_code);
        if (DW < 32 && int'(width) > DW) width = 6'(DW);
        k   = ({1'b0, pos} >= half) ? ({1'b0, pos} - half) : {1'b0, pos};
        idx = lsb_first ? int'(k) : (int'(width) - 1 - int'(k));
        if (run && (k < {3'b0, width}) && idx >= 0 && idx < DW)
            bit_out = word[idx];
        else
            bit_out = 1'b0;
    end
endmodule

// File: rtl/aud_tx.sv
module aud_tx #(
    parameter int DEPTH = 8,
    parameter int DW    = 32,
    localparam int LVW  = $clog2(DEPTH) + 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           enable,
    input  logic [2:0]     cfg_size,
    input  logic [7:0]     cfg_frl,
    input  logic           cfg_mono,
    input  logic           cfg_lsb_first,
    input  logic           cfg_mclk_on,
    input  logic [2:0]     cfg_thresh,
    input  logic           urun_ie,
    input  logic           flag_clr,
    input  logic           wr_en,
    input  logic [DW-1:0]  wr_data,
    output logic [LVW-1:0] fifo_level,
    output logic           dreq,
    output logic           active,
    output logic           sclk,
    output logic           fsync,
    output logic           sdata,
    output logic           urun_flag,
    output logic           urun_irq,
    output logic           wck_err
);
    typedef struct packed {
        logic          ph;     // bit-clock phase: 1 = high half
        logic          run;
        logic [7:0]    pos;    // bit index inside the frame
        logic [DW-1:0] word;   // sample for the current slot
        logic          muted;
        logic          miss;   // slot index that ran dry
        logic          urun;
        logic          wck;
    } st_t;

    st_t           st_q, st_d;
    logic          pop, do_load, ld_slot, base_muted;
    logic [DW-1:0] head;
    logic [8:0]    frame_len, half;
    logic          len_pow2, fifo_empty;

    assign frame_len  = {1'b0, cfg_frl} + 9'd1;
    assign half       = frame_len >> 1;
    assign len_pow2   = ((frame_len & (frame_len - 9'd1)) == 9'd0);
    assign fifo_empty = (fifo_level == '0);

    aud_tx_fifo #(.DEPTH(DEPTH), .DW(DW)) u_fifo (
        .clk(clk), .rst_n(rst_n), .push(wr_en), .push_data(wr_data),
        .pop(pop), .head(head), .level(fifo_level)
    );

    aud_tx_thresh #(.DEPTH(DEPTH)) u_thr (
        .thresh(cfg_thresh), .level(fifo_level), .req(dreq)
    );

    aud_tx_bitsel #(.DW(DW)) u_sel (
        .run(st_q.run), .word(st_q.word), .pos(st_q.pos), .half(half),
        .size_code(cfg_size), .lsb_first(cfg_lsb_first), .bit_out(sdata)
    );

    always_comb begin
        st_d       = st_q;
        pop        = 1'b0;
        do_load    = 1'b0;
        ld_slot    = 1'b0;
        base_muted = st_q.muted;
        if (flag_clr) begin
            st_d.urun = 1'b0;
            st_d.wck  = 1'b0;
        end
        if (!st_q.run) begin
            if (enable) begin
                st_d.run   = 1'b1;
                st_d.ph    = 1'b0;
                st_d.pos   = '0;
                base_muted = 1'b0;
                do_load    = 1'b1;
                if (cfg_mclk_on && (!len_pow2 || frame_len < 9'd8))
                    st_d.wck = 1'b1;
            end
        end else begin
            st_d.ph = ~st_q.ph;
            if (st_q.ph) begin
                if (st_q.pos == cfg_frl) begin
                    st_d.pos = '0;
                    if (!enable) begin
                        st_d.run   = 1'b0;
                        st_d.word  = '0;
                        st_d.muted = 1'b0;
                    end else begin
                        do_load = 1'b1;
                    end
                end else begin
                    st_d.pos = st_q.pos + 8'd1;
                    if ({1'b0, st_d.pos} == half) begin
                        do_load = 1'b1;
                        ld_slot = 1'b1;
                    end
                end
            end
        end
        if (do_load) begin
            st_d.muted = base_muted;
            if (!(cfg_mono && ld_slot)) begin
                if (base_muted && st_q.miss != ld_slot) begin
                    st_d.word = '0;
                end else if (!fifo_empty) begin
                    pop        = 1'b1;
                    st_d.word  = head;
                    st_d.muted = 1'b0;
                end else begin
                    st_d.word  = '0;
                    st_d.muted = 1'b1;
                    st_d.miss  = ld_slot;
                    st_d.urun  = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign active    = st_q.run;
    assign sclk      = st_q.run & st_q.ph;
    assign fsync     = st_q.run && ({1'b0, st_q.pos} < half);
    assign urun_flag = st_q.urun;
    assign urun_irq  = st_q.urun & urun_ie;
    assign wck_err   = st_q.wck;
endmodule

// File: rtl/aud_tx_chk.sv
module aud_tx_chk #(
    parameter int DEPTH = 8,
    localparam int LVW  = $clog2(DEPTH) + 1
) (
    input logic           clk,
    input logic           rst_n,
    input logic           enable,
    input logic           flag_clr,
    input logic           urun_ie,
    input logic           active,
    input logic           sclk,
    input logic           fsync,
    input logic           sdata,
    input logic [LVW-1:0] fifo_level,
    input logic           urun_flag,
    input logic           urun_irq
);
    // R12
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !active |-> (!sclk && !fsync && !sdata));

    // R12
    sclk_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (active && $past(active)) |-> (sclk != $past(sclk)));

    // R5
    level_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_level <= LVW'(DEPTH));

    // R8
    urun_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (urun_flag && !flag_clr) |=> urun_flag);

    // R8
    irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        urun_irq |-> (urun_flag && urun_ie));

    // R9
    stop_after_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(active) |-> !$past(enable));
endmodule

bind aud_tx aud_tx_chk #(.DEPTH(DEPTH)) u_chk (
    .clk(clk), .rst_n(rst_n), .enable(enable), .flag_clr(flag_clr),
    .urun_ie(urun_ie), .active(active), .sclk(sclk), .fsync(fsync),
    .sdata(sdata), .fifo_level(fifo_level), .urun_flag(urun_flag),
    .urun_irq(urun_irq)
);

// File: tb/tb_aud_tx.sv
module tb_aud_tx;
    logic        clk = 0, rst_n = 0;
    logic        enable = 0, cfg_mono = 0, cfg_lsb_first = 0, cfg_mclk_on = 0;
    logic [2:0]  cfg_size = 3'b100, cfg_thresh = 3'd0;
    logic [7:0]  cfg_frl = 8'd31;
    logic        urun_ie = 0, flag_clr = 0, wr_en = 0;
    logic [31:0] wr_data = 0;
    logic [3:0]  fifo_level;
    logic        dreq, active, sclk, fsync, sdata, urun_flag, urun_irq, wck_err;

    aud_tx dut (.*);

    always #4 clk = ~clk;  // 125 MHz

    int n_chk = 0, n_bad = 0, cyc = 0;
    logic        cap_bit [1024];
    logic        cap_fs  [1024];
    int          ncap = 0;
    logic        cap_clr = 0, prev_sclk = 0;
    logic [31:0] es [32];

    // vector: {size, frl, mono, lsb, seed}
    localparam logic [44:0] VEC [6] = '{
        {3'b100, 8'd63, 1'b0, 1'b0, 32'h1234_ABCD},
        {3'b110, 8'd31, 1'b0, 1'b1, 32'hDEAD_BEEF},
        {3'b010, 8'd15, 1'b1, 1'b1, 32'h0000_00A5},
        {3'b111, 8'd63, 1'b0, 1'b1, 32'hC3C3_5A5A},
        {3'b011, 8'd23, 1'b1, 1'b0, 32'h0000_02B7},
        {3'b101, 8'd47, 1'b0, 1'b0, 32'h000F_1E2D}
    };

    always @(negedge clk) begin
        if (cap_clr) ncap = 0;
        else if (sclk && !prev_sclk && ncap < 1024) begin
            cap_bit[ncap] = sdata;
            cap_fs[ncap]  = fsync;
            ncap++;
        end
        prev_sclk = sclk;
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: run hung, actual=%0d expected<=150000", cyc);
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic int width_of(input logic [2:0] c);
        case (c)
            3'b011: return 10; 3'b100: return 16; 3'b101: return 20;
            3'b110: return 24; 3'b111: return 32; default: return 8;
        endcase
    endfunction

    task automatic cap_reset();
        @(negedge clk); cap_clr = 1;
        @(negedge clk); @(negedge clk); cap_clr = 0;
    endtask

    task automatic push(input logic [31:0] d);
        @(negedge clk); wr_en = 1; wr_data = d;
        @(negedge clk); wr_en = 0;
    endtask

    task automatic pulse_clr();
        @(negedge clk); flag_clr = 1;
        @(negedge clk); flag_clr = 0;
    endtask

    // enable, drop enable once the FIFO is drained, check the graceful stop
    task automatic run_until_drained(input string tag);
        int n = 0;
        int len = int'(cfg_frl) + 1;
        @(negedge clk); enable = 1;
        @(negedge clk);
        while (fifo_level != 0) @(negedge clk);
        enable = 0;
        @(negedge clk);
        check(active == 1'b1, "R9", {tag, " active held after drop"}, active, 1);
        while (active && n < 4 * len) begin @(negedge clk); n++; end
        check(active == 1'b0 && n <= 2 * len, "R9", {tag, " stop within frame"}, n, 2 * len);
        repeat (4) @(negedge clk);
    endtask

    task automatic compare(input int nf, input string tag);
        int len = int'(cfg_frl) + 1;
        int hf = len / 2;
        int d = width_of(cfg_size);
        int bad_d = 0, bad_f = 0;
        check(ncap == nf * len, "R2 R9", {tag, " captured bits"}, ncap, nf * len);
        for (int i = 0; i < nf * len && i < ncap; i++) begin
            int f = i / len, p = i % len;
            int s = (p >= hf) ? 1 : 0;
            int k = p - (s ? hf : 0);
            logic [31:0] w = es[2 * f + s];
            logic eb = (k < d) ? (cfg_lsb_first ? w[k] : w[d - 1 - k]) : 1'b0;
            if (cap_bit[i] !== eb) bad_d++;
            if (cap_fs[i] !== (p < hf)) bad_f++;
        end
        check(bad_d == 0, "R1 R3 R4 R7", {tag, " data bit mismatches"}, bad_d, 0);
        check(bad_f == 0, "R2", {tag, " fsync mismatches"}, bad_f, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R11 reset state
        check({active, sclk, fsync, sdata, urun_flag, wck_err} == 6'b0, "R11",
              "outputs after reset", {active, sclk, fsync, sdata, urun_flag, wck_err}, 0);
        check(fifo_level == 0 && dreq == 1, "R11", "level and dreq after reset",
              {fifo_level, dreq}, 1);
        rst_n = 1;
        @(negedge clk);
        check(sclk == 0 && sdata == 0, "R12", "idle pins low", {sclk, sdata}, 0);

        // table of vectors
        for (int v = 0; v < 6; v++) begin
            logic [31:0] seed = VEC[v][31:0];
            logic [31:0] w [4];
            cfg_size = VEC[v][44:42]; cfg_frl = VEC[v][41:34];
            cfg_mono = VEC[v][33];    cfg_lsb_first = VEC[v][32];
            for (int i = 0; i < 4; i++) w[i] = seed ^ (32'(i) * 32'h9E37_79B9) ^ (32'(i) << 3);
            for (int i = 0; i < 4; i++) begin
                if (cfg_mono) begin es[2*i] = w[i]; es[2*i+1] = w[i]; end
                else es[i] = w[i];
            end
            cap_reset();
            for (int i = 0; i < 4; i++) push(w[i]);
            run_until_drained($sformatf("vec%0d", v));
            compare(cfg_mono ? 4 : 2, $sformatf("vec%0d", v));
            check(urun_flag == 0, "R8", $sformatf("vec%0d no underrun", v), urun_flag, 0);
        end

        // R6 thresholds and R5 overflow
        cfg_size = 3'b100; cfg_frl = 8'd31; cfg_mono = 0; cfg_lsb_first = 0;
        cfg_thresh = 3'd0; @(negedge clk); #1;
        check(dreq == 1, "R6", "empty thresh at level 0", dreq, 1);
        cap_reset();
        for (int i = 0; i < 9; i++) begin
            push(32'h0000_1357 + 32'(i) * 32'h0101_0101);
            if (i < 8) es[i] = 32'h0000_1357 + 32'(i) * 32'h0101_0101;
            if (i == 0) begin
                cfg_thresh = 3'd0; #1;
                check(dreq == 0, "R6", "empty thresh at level 1", dreq, 0);
            end
            if (i == 1) begin
                cfg_thresh = 3'd1; #1;
                check(dreq == 1, "R6", "quarter thresh at level 2", dreq, 1);
            end
            if (i == 2) begin
                #1; check(dreq == 0, "R6", "quarter thresh at level 3", dreq, 0);
                cfg_thresh = 3'd2; #1;
                check(dreq == 1, "R6", "half thresh at level 3", dreq, 1);
            end
            if (i == 6) begin
                cfg_thresh = 3'd3; #1;
                check(dreq == 0, "R6", "3/4 thresh at level 7", dreq, 0);
                cfg_thresh = 3'd4; #1;
                check(dreq == 1, "R6", "full thresh at level 7", dreq, 1);
            end
        end
        #1;
        check(fifo_level == 8, "R5", "level after nine writes", fifo_level, 8);
        check(dreq == 0, "R6", "full thresh at level 8", dreq, 0);
        run_until_drained("overflow");
        compare(4, "overflow R5");

        // R7 slot-aware underrun recovery
        cfg_size = 3'b010; cfg_frl = 8'd15; cfg_mono = 0; cfg_lsb_first = 0;
        es[0] = 32'hA1; es[1] = 0; es[2] = 0; es[3] = 32'hB2; es[4] = 32'hC3; es[5] = 32'hD4;
        cap_reset();
        push(32'hA1);
        @(negedge clk); enable = 1;
        while (!urun_flag) @(negedge clk);
        check(active == 1, "R7", "underrun during frame 0", active, 1);
        push(32'hB2); push(32'hC3); push(32'hD4);
        while (fifo_level != 0) @(negedge clk);
        enable = 0;
        while (active) @(negedge clk);
        repeat (3) @(negedge clk);
        compare(3, "underrun");

        // R8 sticky flag and interrupt gate
        urun_ie = 0; #1;
        check(urun_flag == 1 && urun_irq == 0, "R8", "flag kept, irq masked",
              {urun_flag, urun_irq}, 2'b10);
        urun_ie = 1; #1;
        check(urun_irq == 1, "R8", "irq when enabled", urun_irq, 1);
        pulse_clr(); #1;
        check(urun_flag == 0 && urun_irq == 0, "R8", "flag cleared",
              {urun_flag, urun_irq}, 0);
        urun_ie = 0;

        // R10 frame-length check at start
        for (int t = 0; t < 4; t++) begin
            logic [7:0] frl_t = (t == 1) ? 8'd31 : (t == 2) ? 8'd3 : 8'd23;
            logic       mc    = (t != 3);
            logic       expf  = (t == 0) || (t == 2);
            cfg_frl = frl_t; cfg_mclk_on = mc;
            @(negedge clk); enable = 1;
            @(negedge clk);
            check(wck_err == expf, "R10", $sformatf("frl=%0d mclk=%0d", frl_t, mc),
                  wck_err, expf);
            enable = 0;
            while (active) @(negedge clk);
            pulse_clr();
            #1;
            check(wck_err == 0 && urun_flag == 0, "R10", "flags cleared",
                  {wck_err, urun_flag}, 0);
        end

        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule